// File: doc/BRIEF.md
# Fractional Reference Clock Divider

This block produces a divided copy of a reference clock on a single output. A 6-bit selection code chooses the ratio. Only the top sixteen codes (48 to 63) select the divider. Those ratios are a fixed mix of powers of two, three times powers of two, and one non-integer ratio of 1.5. Lower codes leave the divider idle, with its output held low.

The divider counts in reference half-cycles. A register clocked on the rising edge sets the output level for each high half of the reference clock. A register clocked on the falling edge sets it for each low half. The output is a mux of the two, selected by the reference clock level. This lets the divide-by-1.5 and divide-by-3 ratios place their edges on either reference edge. A new code is taken only when the current output period ends, so a ratio change never produces a short pulse. Clearing the enable stops the output at the next rising edge.

Top module: `xo_frac_divider`

## Requirements
- R1: While reset is asserted, the output is low. After reset, it stays low until the divider is enabled.
- R2: With the enable high and a code below 48, the output stays low.
- R3: Code 48 passes the reference clock through: an output period of 2 half-cycles, high for 1.
- R4: Code 49 divides by 1.5: an output period of 3 reference half-cycles, high for 2 of them, giving two output periods per three reference periods.
- R5: Codes 50 and 52 to 63 divide by 2, 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128 and 192 respectively. Each gives a period of twice the ratio in half-cycles and a high time of exactly half that period.
- R6: Code 51 divides by 3: a period of 6 half-cycles, high for 3, so the falling output edge lands on a falling reference edge.
- R7: A period starts high in the reference high half-cycle after the first rising edge that samples the enable high with a valid code.
- R8: A code change made during a period is not applied until that period ends. The running period finishes with its old period and high time, and the new ratio starts at the next period.
- R9: At the first rising edge that samples the enable low, the output goes low and stays low. The counters return to their start state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_code | input | 6 | Ratio selection code; 48 to 63 select the divider |
| div_en | input | 1 | Divider enable, sampled on rising edges |
| div_clk | output | 1 | Divided clock; low when idle |

## Verification
The assertions assume that `sel_code` and `div_en` change only away from rising reference edges, so each rising edge samples a settled value. The bench changes these inputs only in the middle of a reference half-cycle. The assertions also assume that the output mux reads the rising-edge register during the high half and the falling-edge register during the low half. The bench therefore samples `div_clk` only at the middle of each half-cycle. There, both registers are settled, and any zero-width transition at a reference edge cannot be seen.

// File: rtl/xfd_pkg.sv
package xfd_pkg;

  // Output period, in reference half-cycles, for table slot idx.
  // Even slots: powers of two; odd slots: three times powers of two.
  function automatic int unsigned half_period(input int unsigned idx);
    if (idx % 2 == 0) return 2 << (idx / 2);
    else              return 3 << ((idx - 1) / 2);
  endfunction

  // High time in half-cycles: half the period, rounded up.
  function automatic int unsigned half_high(input int unsigned idx);
    return (half_period(idx) + 1) / 2;
  endfunction

endpackage

// File: rtl/xfd_ratio_rom.sv
module xfd_ratio_rom #(
  parameter int IDX_W  = 4,
  parameter int HALF_W = 9
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [HALF_W-1:0] period,
  output logic [HALF_W-1:0] high,
  output logic              odd
);
  localparam int NUM = 1 << IDX_W;

  logic [HALF_W-1:0] p_tbl [NUM];
  logic [HALF_W-1:0] h_tbl [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_slot
    assign p_tbl[g] = HALF_W'(xfd_pkg::half_period(g));
    assign h_tbl[g] = HALF_W'(xfd_pkg::half_high(g));
  end

  assign period = p_tbl[idx];
  assign high   = h_tbl[idx];
  assign odd    = period[0];
endmodule

// File: rtl/xfd_phase.sv
module xfd_phase #(
  parameter int HALF_W = 9
) (
  input  logic [HALF_W:0]   k,
  input  logic [HALF_W-1:0] period,
  input  logic [HALF_W-1:0] high,
  input  logic              odd,
  output logic              level
);
  // Half-cycle k within a repeat of one period (even) or two periods (odd).
  logic [HALF_W:0] p_ext, h_ext, second_end;

  assign p_ext      = {1'b0, period};
  assign h_ext      = {1'b0, high};
  assign second_end = p_ext + h_ext;

  always_comb begin
    level = (k < h_ext);
    if (odd && (k >= p_ext) && (k < second_end)) level = 1'b1;
  end
endmodule

// File: rtl/xfd_rise_seq.sv
module xfd_rise_seq #(
  parameter int IDX_W  = 4,
  parameter int HALF_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [HALF_W-1:0] period,
  input  logic              odd,
  input  logic              ph_next,
  output logic              act,
  output logic [IDX_W-1:0]  idx,
  output logic [HALF_W-1:0] cnt,
  output logic              pos_q
);
  logic [HALF_W-1:0] last;

  // Rising edges per repeat: one period if even, two periods if odd.
  assign last = odd ? (period - HALF_W'(1)) : ((period >> 1) - HALF_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act   <= 1'b0;
      idx   <= '0;
      cnt   <= '0;
      pos_q <= 1'b0;
    end else if (!go) begin
      act   <= 1'b0;
      cnt   <= '0;
      pos_q <= 1'b0;
    end else if (!act || cnt == last) begin
      act   <= 1'b1;
      idx   <= req_idx;
      cnt   <= '0;
      pos_q <= 1'b1;
    end else begin
      cnt   <= cnt + HALF_W'(1);
      pos_q <= ph_next;
    end
  end

  a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> (!act && !pos_q && cnt == '0));

  a_r7_start_high: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !act) |=> (act && pos_q && cnt == '0));

  a_r8_hold_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    (act && cnt != '0) |-> (idx == $past(idx)));

  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> (cnt <= last));
endmodule

// File: rtl/xfd_fall_stage.sv
module xfd_fall_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  input  logic ph_fall,
  output logic neg_q
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) neg_q <= 1'b0;
    else        neg_q <= act & ph_fall;
  end

  a_r1_fall_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !act |-> !neg_q);
endmodule

// File: rtl/xo_frac_divider.sv
module xo_frac_divider #(
  parameter int SEL_W = 6,
  parameter int IDX_W = 4
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_code,
  input  logic             div_en,
  output logic             div_clk
);
  localparam int NUM    = 1 << IDX_W;
  localparam int BASE   = (1 << SEL_W) - NUM;
  localparam int HALF_W = NUM / 2 + 1;

  logic              go;
  logic              act, pos_q, neg_q;
  logic [IDX_W-1:0]  idx;
  logic [HALF_W-1:0] cnt, cnt_inc;
  logic [HALF_W-1:0] period, high;
  logic              odd;
  logic [HALF_W:0]   k_rise, k_fall;
  logic              ph_rise, ph_fall;

  assign go      = div_en && (sel_code >= SEL_W'(BASE));
  assign cnt_inc = cnt + HALF_W'(1);
  assign k_rise  = {cnt_inc, 1'b0};
  assign k_fall  = {cnt, 1'b1};

  xfd_ratio_rom #(.IDX_W(IDX_W), .HALF_W(HALF_W)) u_rom (
    .idx(idx), .period(period), .high(high), .odd(odd)
  );

  xfd_phase #(.HALF_W(HALF_W)) u_ph_rise (
    .k(k_rise), .period(period), .high(high), .odd(odd), .level(ph_rise)
  );

  xfd_phase #(.HALF_W(HALF_W)) u_ph_fall (
    .k(k_fall), .period(period), .high(high), .odd(odd), .level(ph_fall)
  );

  xfd_rise_seq #(.IDX_W(IDX_W), .HALF_W(HALF_W)) u_rise (
    .clk(ref_clk), .rst_n(rst_n), .go(go),
    .req_idx(sel_code[IDX_W-1:0]),
    .period(period), .odd(odd), .ph_next(ph_rise),
    .act(act), .idx(idx), .cnt(cnt), .pos_q(pos_q)
  );

  xfd_fall_stage u_fall (
    .clk(ref_clk), .rst_n(rst_n), .act(act), .ph_fall(ph_fall), .neg_q(neg_q)
  );

  // High half of the reference takes the rising-edge level, low half the falling-edge level.
  assign div_clk = ref_clk ? pos_q : neg_q;

  a_r2_low_code_idle: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (div_en && sel_code < SEL_W'(BASE)) |=> !act);
endmodule

// File: tb/xo_frac_divider_test.sv
`timescale 1ns/1ps
module xo_frac_divider_test;
  logic       ref_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic [5:0] sel_code = 6'd0;
  logic       div_en  = 1'b0;
  logic       div_clk;

  int total = 0;
  int bad   = 0;

  xo_frac_divider uut (
    .ref_clk(ref_clk), .rst_n(rst_n), .sel_code(sel_code),
    .div_en(div_en), .div_clk(div_clk)
  );

  always #10 ref_clk = ~ref_clk;

  // Expected period per code 48..63, in reference half-cycles (twice the ratio).
  int exp_p [16] = '{2, 3, 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128, 192, 256, 384};

  task automatic check(input bit ok, input string req, input int act_v, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  // Sample the output in the middle of the next reference half-cycle.
  task automatic get_half(output logic v);
    @(ref_clk);
    #5;
    v = div_clk;
  endtask

  task automatic sync_low();
    @(negedge ref_clk);
    #5;
  endtask

  task automatic count_ones(input int n, output int ones);
    logic v;
    ones = 0;
    for (int i = 0; i < n; i++) begin
      get_half(v);
      if (v) ones++;
    end
  endtask

  task automatic run_len(inout logic s, input logic lvl, output int n);
    n = 0;
    while (s === lvl && n < 1000) begin
      n++;
      get_half(s);
    end
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ones, hh, ll, p, h;
    logic s;
    string tag;

    // R1: low under reset and after reset while idle
    sel_code = 6'd50;
    count_ones(8, ones);
    check(ones == 0, "R1 reset low", ones, 0);
    sync_low();
    rst_n = 1'b1;
    count_ones(8, ones);
    check(ones == 0, "R1 idle after reset", ones, 0);

    // R2: codes below the divider range stay low even when enabled
    sync_low();
    sel_code = 6'd20;
    div_en = 1'b1;
    count_ones(10, ones);
    check(ones == 0, "R2 code 20", ones, 0);
    sync_low();
    sel_code = 6'd47;
    count_ones(10, ones);
    check(ones == 0, "R2 code 47", ones, 0);
    sync_low();
    div_en = 1'b0;
    count_ones(4, ones);

    // Sweep over every divider code
    for (int i = 0; i < 16; i++) begin
      p = exp_p[i];
      h = (p + 1) / 2;
      tag = (i == 0) ? "R3" : (i == 1) ? "R4" : (i == 3) ? "R6" : "R5";
      sync_low();
      sel_code = 6'(48 + i);
      div_en = 1'b1;
      get_half(s);
      check(s === 1'b1, "R7 first half high", int'(s), 1);
      for (int k = 0; k < 3; k++) begin
        run_len(s, 1'b1, hh);
        run_len(s, 1'b0, ll);
        check(hh == h, {tag, " high time"}, hh, h);
        check(hh + ll == p, {tag, " period"}, hh + ll, p);
      end
      sync_low();
      div_en = 1'b0;
      count_ones(8, ones);
      check(ones == 0, "R9 disable low", ones, 0);
    end

    // R8: change from code 63 to 48 in the middle of a long period
    sync_low();
    sel_code = 6'd63;
    div_en = 1'b1;
    get_half(s);
    hh = 0;
    while (s === 1'b1 && hh < 1000) begin
      hh++;
      if (hh == 50) sel_code = 6'd48;
      get_half(s);
    end
    check(hh == 192, "R8 old high kept", hh, 192);
    run_len(s, 1'b0, ll);
    check(ll == 192, "R8 old low kept", ll, 192);
    for (int k = 0; k < 2; k++) begin
      run_len(s, 1'b1, hh);
      run_len(s, 1'b0, ll);
      check(hh == 1 && ll == 1, "R8 new ratio period", hh + ll, 2);
    end

    // R8: change from 1.5 to 8 right after a period boundary
    sync_low();
    div_en = 1'b0;
    count_ones(4, ones);
    sync_low();
    sel_code = 6'd49;
    div_en = 1'b1;
    get_half(s);
    sel_code = 6'd54;
    run_len(s, 1'b1, hh);
    run_len(s, 1'b0, ll);
    check(hh == 2 && ll == 1, "R8 1.5 period kept", hh + ll, 3);
    run_len(s, 1'b1, hh);
    run_len(s, 1'b0, ll);
    check(hh + ll == 3 || hh + ll == 16, "R8 next period", hh + ll, 16);
    run_len(s, 1'b1, hh);
    check(hh == 8, "R8 ratio 8 high", hh, 8);
    sync_low();
    div_en = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule